// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and calendar date in packed BCD: seconds, minutes, hours, date of month, month, day of week, year and century. A free-running prescaler counts enable pulses from a 32.768 kHz source. Every `TICKS_PER_SEC` pulses it produces a one-second step, and that step ripples through the fields with the usual carries. Hours can be kept in 24-hour form or in 12-hour form with a PM flag. The date wraps at the true length of each month, and February gains a day in leap years.

Software-side logic sets the time through a parallel load port. A single strobe writes the fields whose enable bits are set and restarts the prescaler, so that counting resumes from the loaded time. A status byte holds three bits: an oscillator-off control that freezes counting, a sensing-disable control, and a sticky stop flag. The stop flag records that counting was halted, and it can only be cleared by software.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the seconds, minutes, hours, date, month, day-of-week and year outputs read 00, the century reads 19 and the status reads 04h (only the stop flag set).
- R2: The seconds field advances exactly once for every `TICKS_PER_SEC` clock cycles with `tick_32k` high, counting only those cycles and not idle ones.
- R3: Seconds and minutes count 00 to 59 in BCD. Seconds wrapping to 00 advances minutes, and minutes wrapping to 00 advances hours.
- R4: With hours bit 7 clear (24-hour form), hours count 00 to 23 and bit 5 is the tens digit 2. 23 wrapping to 00 advances the date and the day of week.
- R5: With hours bit 7 set (12-hour form), bits 4..0 hold hours 01 to 12 and bit 5 is PM. 11 advancing to 12 toggles PM, and 12 advances to 01. The date advances when 11 PM becomes 12 AM.
- R6: The date wraps to 01 and advances the month after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months, except February (R7).
- R7: February ends after day 29 when the combined century and year value is divisible by 4, and after day 28 otherwise.
- R8: Month 12 wrapping to 01 advances the year. Year 99 wrapping to 00 advances the century, and century 99 wraps to 00.
- R9: The day of week counts 1 to 7, wraps 7 to 1, and advances together with the date.
- R10: A `load` cycle writes each field whose `ld_we` bit is set (bit 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year, 7 century, 8 status) and leaves the others unchanged. It overrides a coincident tick and restarts the prescaler, so the next step comes after `TICKS_PER_SEC` further ticks.
- R11: While status bit 7 (oscillator off) is 1, no field changes except through a load.
- R12: Status bit 2 (stop flag) is set by reset and by a load that changes bit 7 from 0 to 1. A load of bit 2 as 0 clears it, and a load of bit 2 as 1 leaves it unchanged.
- R13: While status bit 6 (sensing off) is 1, the stop flag reads 0 and cannot be set. Status bits 5, 4, 3, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| load | input | 1 | Load strobe for the parallel write port |
| ld_we | input | 9 | Per-field write enables |
| ld_sec | input | 8 | Seconds load value (BCD) |
| ld_min | input | 8 | Minutes load value (BCD) |
| ld_hour | input | 8 | Hours load value (mode, PM/20 bit, BCD) |
| ld_date | input | 8 | Date load value (BCD) |
| ld_month | input | 8 | Month load value (BCD) |
| ld_dow | input | 8 | Day-of-week load value |
| ld_year | input | 8 | Year load value (BCD) |
| ld_cent | input | 8 | Century load value (BCD) |
| ld_status | input | 8 | Status load value |
| t_sec | output | 8 | Seconds |
| t_min | output | 8 | Minutes |
| t_hour | output | 8 | Hours |
| t_date | output | 8 | Date of month |
| t_month | output | 8 | Month |
| t_dow | output | 8 | Day of week |
| t_year | output | 8 | Year |
| t_cent | output | 8 | Century |
| t_status | output | 8 | Status |

## Verification
The hardest situations to reach from the ports are the long carry chains: a leap-year February end, a century rollover, and 11 PM turning into the next day in 12-hour form. At one step per second, these would take years of simulated time to arrive. The stimulus therefore loads times a few seconds before each boundary, both directed and drawn at random near month, year and hour edges, with a short prescaler. A load landing on the same cycle as the prescaler's final tick is arranged by counting the ticks driven since the previous load.

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar #(
  parameter int TICKS_PER_SEC = 32768,
  localparam int PW = $clog2(TICKS_PER_SEC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       load,
  input  logic [8:0] ld_we,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_date,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_dow,
  input  logic [7:0] ld_year,
  input  logic [7:0] ld_cent,
  input  logic [7:0] ld_status,
  output logic [7:0] t_sec,
  output logic [7:0] t_min,
  output logic [7:0] t_hour,
  output logic [7:0] t_date,
  output logic [7:0] t_month,
  output logic [7:0] t_dow,
  output logic [7:0] t_year,
  output logic [7:0] t_cent,
  output logic [7:0] t_status
);

  localparam logic [PW-1:0] LAST_TICK = PW'(TICKS_PER_SEC - 1);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [PW-1:0] pre_q;
  logic [7:0] sec_q, min_q, hour_q, date_q, month_q, dow_q, year_q, cent_q;
  logic       osc_off, sense_off, stop_flag;

  wire unused_status_bits = ^{ld_status[5:3], ld_status[1:0]};

  wire step     = tick_32k && !osc_off && (pre_q == LAST_TICK);
  wire c_min    = step && (sec_q == 8'h59);
  wire c_hour   = c_min && (min_q == 8'h59);

  wire        mode12 = hour_q[7];
  wire [7:0]  hv12   = {3'b000, hour_q[4:0]};
  wire [7:0]  hv24   = {2'b00, hour_q[5:0]};
  wire [7:0]  inc12  = bcd_inc(hv12);
  wire [7:0]  inc24  = bcd_inc(hv24);
  wire        day_wrap = mode12 ? (hour_q[5] && hv12 == 8'h11) : (hv24 == 8'h23);
  wire c_day    = c_hour && day_wrap;

  logic [7:0] hour_nx;
  always_comb begin
    if (mode12) begin
      if (hv12 == 8'h12)      hour_nx = {hour_q[7:5], 5'h01};
      else if (hv12 == 8'h11) hour_nx = {hour_q[7:6], ~hour_q[5], 5'h12};
      else                    hour_nx = {hour_q[7:5], inc12[4:0]};
    end else begin
      hour_nx = (hv24 == 8'h23) ? {hour_q[7:6], 6'h00} : {hour_q[7:6], inc24[5:0]};
    end
  end

  wire leap = year_q[4] ? (year_q[3:0] == 4'd2 || year_q[3:0] == 4'd6)
                        : (year_q[3:0] == 4'd0 || year_q[3:0] == 4'd4 || year_q[3:0] == 4'd8);

  logic [7:0] last_day;
  always_comb begin
    case (month_q)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  wire c_mon  = c_day && (date_q == last_day);
  wire c_yr   = c_mon && (month_q == 8'h12);
  wire c_cent = c_yr && (year_q == 8'h99);

  wire off_nx   = ld_we[8] ? ld_status[7] : osc_off;
  wire sense_nx = ld_we[8] ? ld_status[6] : sense_off;
  wire flag_nx  = sense_nx ? 1'b0 :
                  (off_nx && !osc_off) ? 1'b1 :
                  (ld_we[8] && !ld_status[2]) ? 1'b0 : stop_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      sec_q <= 8'h00; min_q <= 8'h00; hour_q <= 8'h00; date_q <= 8'h00;
      month_q <= 8'h00; dow_q <= 8'h00; year_q <= 8'h00; cent_q <= 8'h19;
      osc_off <= 1'b0; sense_off <= 1'b0; stop_flag <= 1'b1;
    end else if (load) begin
      pre_q <= '0;
      if (ld_we[0]) sec_q   <= ld_sec;
      if (ld_we[1]) min_q   <= ld_min;
      if (ld_we[2]) hour_q  <= ld_hour;
      if (ld_we[3]) date_q  <= ld_date;
      if (ld_we[4]) month_q <= ld_month;
      if (ld_we[5]) dow_q   <= ld_dow;
      if (ld_we[6]) year_q  <= ld_year;
      if (ld_we[7]) cent_q  <= ld_cent;
      osc_off   <= off_nx;
      sense_off <= sense_nx;
      stop_flag <= flag_nx;
    end else begin
      if (tick_32k && !osc_off) pre_q <= (pre_q == LAST_TICK) ? '0 : pre_q + 1'b1;
      if (step)   sec_q   <= (sec_q == 8'h59) ? 8'h00 : bcd_inc(sec_q);
      if (c_min)  min_q   <= (min_q == 8'h59) ? 8'h00 : bcd_inc(min_q);
      if (c_hour) hour_q  <= hour_nx;
      if (c_day)  dow_q   <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
      if (c_day)  date_q  <= (date_q == last_day) ? 8'h01 : bcd_inc(date_q);
      if (c_mon)  month_q <= (month_q == 8'h12) ? 8'h01 : bcd_inc(month_q);
      if (c_yr)   year_q  <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
      if (c_cent) cent_q  <= (cent_q == 8'h99) ? 8'h00 : bcd_inc(cent_q);
    end
  end

  assign t_sec    = sec_q;
  assign t_min    = min_q;
  assign t_hour   = hour_q;
  assign t_date   = date_q;
  assign t_month  = month_q;
  assign t_dow    = dow_q;
  assign t_year   = year_q;
  assign t_cent   = cent_q;
  assign t_status = {osc_off, sense_off, 3'b000, stop_flag, 2'b00};

endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_32k,
  input logic       load,
  input logic [7:0] t_sec,
  input logic [7:0] t_min,
  input logic [7:0] t_hour,
  input logic [7:0] t_date,
  input logic [7:0] t_month,
  input logic [7:0] t_dow,
  input logic [7:0] t_year,
  input logic [7:0] t_cent,
  input logic [7:0] t_status
);

  // R2
  sec_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(t_sec) |-> $past(tick_32k || load));

  // R3
  min_after_sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(t_min) && !$past(load)) |-> ($past(t_sec) == 8'h59 && t_sec == 8'h00));

  // R4
  hour_after_min_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(t_hour) && !$past(load)) |-> ($past(t_min) == 8'h59 && t_min == 8'h00));

  // R6
  month_after_date_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(t_month) && !$past(load)) |-> (t_date == 8'h01));

  // R8
  cent_after_year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(t_cent) && !$past(load)) |-> ($past(t_year) == 8'h99 && t_year == 8'h00));

  // R9
  dow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_dow <= 8'h07);

  // R11
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_status[7] && !load) |=> $stable({t_sec, t_min, t_hour, t_date, t_month, t_dow, t_year, t_cent}));

  // R12
  flag_rises_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t_status[2]) |-> $past(load));

  // R13
  sense_off_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_status[6] |-> (t_status[2] == 1'b0 && t_status[5:3] == 3'b000 && t_status[1:0] == 2'b00));

endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .load(load),
  .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_date(t_date),
  .t_month(t_month), .t_dow(t_dow), .t_year(t_year), .t_cent(t_cent),
  .t_status(t_status)
);

// File: tb/rtc_bcd_calendar_tb.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_tb;
  localparam int TICKS = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, load = 1'b0;
  logic [8:0] ld_we = '0;
  logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_date = 0, ld_month = 0;
  logic [7:0] ld_dow = 0, ld_year = 0, ld_cent = 0, ld_status = 0;
  logic [7:0] t_sec, t_min, t_hour, t_date, t_month, t_dow, t_year, t_cent, t_status;

  int checks = 0, errors = 0;
  bit done = 0;
  int es, em, eh, e12, ed, emo, edw, ey, ec;

  always #10 clk = ~clk;

  rtc_bcd_calendar #(.TICKS_PER_SEC(TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick), .load(load), .ld_we(ld_we),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_date(ld_date),
    .ld_month(ld_month), .ld_dow(ld_dow), .ld_year(ld_year), .ld_cent(ld_cent),
    .ld_status(ld_status),
    .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_date(t_date),
    .t_month(t_month), .t_dow(t_dow), .t_year(t_year), .t_cent(t_cent),
    .t_status(t_status));

  function automatic logic [7:0] bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [7:0] hour_byte(input int h, input int m12);
    int hr;
    if (m12 == 0) return bcd(h);
    hr = h % 12;
    if (hr == 0) hr = 12;
    return 8'h80 | ((h >= 12) ? 8'h20 : 8'h00) | bcd(hr);
  endfunction

  function automatic int dim(input int mo, input int y, input int c);
    if (mo == 2) return (((c * 100 + y) % 4) == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic check_byte(input string tag, input string name, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %02h expected %02h", tag, name, act, exp);
    end
  endtask

  task automatic check_time(input string tag);
    logic [71:0] act, exp;
    act = {t_cent, t_year, t_month, t_date, t_dow, t_hour, t_min, t_sec};
    exp = {bcd(ec), bcd(ey), bcd(emo), bcd(ed), bcd(edw), hour_byte(eh, e12), bcd(em), bcd(es)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s time actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_adv();
    es++;
    if (es == 60) begin
      es = 0; em++;
      if (em == 60) begin
        em = 0; eh++;
        if (eh == 24) begin
          eh = 0;
          edw = (edw == 7) ? 1 : edw + 1;
          ed++;
          if (ed > dim(emo, ey, ec)) begin
            ed = 1; emo++;
            if (emo == 13) begin
              emo = 1; ey++;
              if (ey == 100) begin ey = 0; ec = (ec + 1) % 100; end
            end
          end
        end
      end
    end
  endtask

  task automatic do_load(input logic [8:0] we, input logic with_tick);
    @(negedge clk); ld_we = we; load = 1'b1; tick = with_tick;
    @(negedge clk); ld_we = '0; load = 1'b0; tick = 1'b0;
  endtask

  task automatic set_time(input int c, input int y, input int mo, input int d, input int dw,
                          input int h, input int m, input int s, input int m12);
    ec = c; ey = y; emo = mo; ed = d; edw = dw; eh = h; em = m; es = s; e12 = m12;
    ld_cent = bcd(c); ld_year = bcd(y); ld_month = bcd(mo); ld_date = bcd(d);
    ld_dow = bcd(dw); ld_hour = hour_byte(h, m12); ld_min = bcd(m); ld_sec = bcd(s);
    do_load(9'h0FF, 1'b0);
  endtask

  task automatic one_sec();
    repeat (TICKS) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic run_check(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      one_sec(); model_adv(); check_time(tag);
    end
  endtask

  task automatic write_status(input logic [7:0] v);
    ld_status = v; do_load(9'h100, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_byte("R1", "sec", t_sec, 8'h00);
    check_byte("R1", "min", t_min, 8'h00);
    check_byte("R1", "hour", t_hour, 8'h00);
    check_byte("R1", "date", t_date, 8'h00);
    check_byte("R1", "month", t_month, 8'h00);
    check_byte("R1", "dow", t_dow, 8'h00);
    check_byte("R1", "year", t_year, 8'h00);
    check_byte("R1", "cent", t_cent, 8'h19);
    check_byte("R1", "status", t_status, 8'h04);

    // R2 only enabled cycles count; R7 leap February (2024)
    set_time(20, 24, 2, 28, 3, 23, 59, 58, 0);
    for (int i = 0; i < TICKS - 1; i++) begin
      @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0; repeat (2) @(negedge clk);
    end
    check_time("R2 before last tick");
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    model_adv(); check_time("R2 step");
    run_check(1, "R7 R4 R9 leap Feb 29");

    // R7 non-leap, tens even
    set_time(20, 23, 2, 28, 7, 23, 59, 59, 0);
    run_check(1, "R7 R6 R9 Feb 28 to Mar 1");
    // R7 tens odd, units 2 is leap; units 4 is not
    set_time(20, 12, 2, 28, 1, 23, 59, 59, 0);
    run_check(1, "R7 year 12 leap");
    set_time(20, 14, 2, 28, 1, 23, 59, 59, 0);
    run_check(1, "R7 year 14 not leap");
    // R6 30- and 31-day months
    set_time(19, 85, 4, 30, 2, 23, 59, 59, 0);
    run_check(1, "R6 Apr 30");
    set_time(19, 85, 1, 30, 2, 23, 59, 59, 0);
    run_check(2, "R6 Jan 30/31");
    // R3 minute/hour carry
    set_time(20, 1, 5, 5, 4, 9, 58, 59, 0);
    run_check(62, "R3 sec min carry");
    // R5 12-hour transitions
    set_time(20, 5, 6, 10, 6, 11, 59, 59, 1);
    run_check(1, "R5 11 AM to 12 PM");
    check_byte("R5", "hour 12PM", t_hour, 8'hB2);
    set_time(20, 5, 6, 10, 6, 12, 59, 59, 1);
    run_check(1, "R5 12 PM to 1 PM");
    check_byte("R5", "hour 1PM", t_hour, 8'hA1);
    set_time(20, 5, 6, 10, 7, 23, 59, 59, 1);
    run_check(1, "R5 R9 11 PM to 12 AM");
    check_byte("R5", "hour 12AM", t_hour, 8'h92);
    // R8 year and century rollover
    set_time(19, 99, 12, 31, 5, 23, 59, 59, 0);
    run_check(1, "R8 1999 to 2000");
    set_time(99, 99, 12, 31, 5, 23, 59, 59, 0);
    run_check(1, "R8 century 99 wrap");

    // R10 partial write leaves other fields
    set_time(20, 30, 8, 15, 2, 14, 20, 10, 0);
    ld_min = 8'h42; ld_sec = 8'h33; ld_hour = 8'h01;
    do_load(9'h002, 1'b0);
    em = 42; check_time("R10 minutes only");
    // R10 load beats coincident tick and restarts prescaler
    repeat (TICKS - 1) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
    ld_sec = 8'h05; do_load(9'h001, 1'b1);
    es = 5; check_time("R10 load over tick");
    repeat (TICKS - 1) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
    check_time("R10 prescaler restarted");
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    model_adv(); check_time("R10 step after restart");

    // R12 / R11 / R13 status behaviour
    write_status(8'h00);
    check_byte("R12", "flag cleared", t_status, 8'h00);
    write_status(8'h04);
    check_byte("R12", "write 1 no effect", t_status, 8'h00);
    write_status(8'h80);
    check_byte("R12", "stop sets flag", t_status, 8'h84);
    one_sec(); one_sec();
    check_time("R11 frozen while off");
    write_status(8'h84);
    check_byte("R12", "flag held", t_status, 8'h84);
    write_status(8'h00);
    check_byte("R12", "restart clears", t_status, 8'h00);
    run_check(1, "R11 counting resumes");
    write_status(8'h40);
    write_status(8'hC4);
    check_byte("R13", "sense off blocks flag", t_status, 8'hC0);
    write_status(8'h00);
    write_status(8'hFF);
    check_byte("R13", "unused bits read 0", t_status, 8'hC0);
    write_status(8'h00);
    check_byte("R13", "status clear", t_status, 8'h00);

    // random near-boundary times
    for (int it = 0; it < 40; it++) begin
      int c, y, mo, d, h, m12;
      m12 = $urandom_range(0, 1);
      c = ($urandom_range(0, 3) == 0) ? 99 : $urandom_range(19, 21);
      y = ($urandom_range(0, 2) == 0) ? 99 : $urandom_range(0, 99);
      mo = ($urandom_range(0, 2) == 0) ? 12 : $urandom_range(1, 12);
      d = dim(mo, y, c) - $urandom_range(0, 1);
      case ($urandom_range(0, 3))
        0: h = 11;
        1: h = 12;
        default: h = 23;
      endcase
      set_time(c, y, mo, d, $urandom_range(1, 7), h, 59, $urandom_range(50, 59), m12);
      run_check(12, "R4 R5 R6 R7 R8 R9 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule